// File: doc/BRIEF.md
# Per-Destination Acknowledge Tracker

This block follows one chosen interrupt line whose deliveries fan out to several destinations at once. Each time the line is delivered, the block stores a bitmap of the destinations that took the interrupt and a count of acknowledgements still owed. Every destination that finishes servicing the interrupt sends an end-of-interrupt (EOI) strobe with its own index. That strobe clears the destination's bit and lowers the count. While the count is non-zero, any new assertion of the line is answered as coalesced: the source drops it rather than delivering it again.

The delivery record enters on a valid/ready stream. `rec_ready` is high only when nothing is outstanding and no rebuild is in progress. A producer holds `rec_valid` and its payload steady until a cycle with both signals high, and the record is taken in that cycle. Single-destination resync steps use the same handshake. `sync_ready` drops while an EOI is present or a rebuild runs, so a stalled step waits without being lost. EOI strobes, assertion queries and the rebuild trigger are plain pins and are never held off.

A full rebuild clears the tracking state and then walks the destinations from index 0 upward, one per cycle. At each index it takes the routing-match flag and the pending flag from two bitmap inputs and applies the same rule as a single resync step. It is used after the tracked state has been restored from elsewhere.

Top module: `dest_eoi_tracker`

## Requirements
- R1: After reset `pending_count` is 0, `pending_map` is all zeros, and `underflow_err`, `restore_busy` and `ans_valid` are 0.
- R2: A query (`ask_valid` high at a clock edge) gives `ans_valid` high for the following cycle. In that cycle `ans_coalesced` is 1 exactly when `pending_count` was non-zero in the cycle of the query.
- R3: `rec_ready` is 1 only when `pending_count` is 0, `restore_busy` is 0 and `restore_start` is 0. An accepted record loads `pending_map` from `rec_map` and `pending_count` from `rec_count`, clamped to `N_DEST`. A record offered while `rec_ready` is 0 changes nothing.
- R4: An EOI for an index whose bit is set clears that bit and decrements the count. An EOI for an index whose bit is clear leaves the map and the count unchanged.
- R5: When a record is accepted and an EOI arrives in the same cycle, the record is applied first and the EOI then acts on the newly loaded map and count.
- R6: A resync step for index i changes state only if its match flag is 1 and its pending flag differs from bit i. It then copies the pending flag into bit i and increments the count (flag 1) or decrements it (flag 0).
- R7: `restore_start` while not busy clears the map and the count at the next edge and raises `restore_busy`. The walk then applies R6 to indices 0 to N_DEST-1 with `dest_match[i]` and `dest_pending[i]`, one index per cycle. `restore_busy` falls after the last index. `rec_ready` and `sync_ready` are 0 while busy.
- R8: At most one EOI or one resync step takes effect per cycle, and the EOI has priority. While `eoi_valid` is 1, `sync_ready` is 0 and the rebuild walk does not advance.
- R9: A decrement at count 0 leaves the count at 0 and sets `underflow_err`. An increment at count N_DEST leaves the count at N_DEST and also sets `underflow_err`.
- R10: `underflow_err` stays set until reset. A rebuild does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Delivery record offered |
| rec_ready | output | 1 | Delivery record can be taken |
| rec_map | input | N_DEST | Destinations that accepted the delivery |
| rec_count | input | CW | Number of accepting destinations |
| eoi_valid | input | 1 | EOI strobe |
| eoi_id | input | IW | Index of the acknowledging destination |
| ask_valid | input | 1 | New assertion of the tracked line |
| ans_valid | output | 1 | Answer to the previous cycle's query |
| ans_coalesced | output | 1 | 1: the assertion must be dropped as coalesced |
| sync_valid | input | 1 | Single-destination resync step offered |
| sync_ready | output | 1 | Resync step can be taken |
| sync_id | input | IW | Destination index of the step |
| sync_match | input | 1 | Destination matches the line's routing |
| sync_pending | input | 1 | Destination reports an unacknowledged interrupt |
| restore_start | input | 1 | Start a full rebuild |
| restore_busy | output | 1 | Rebuild walk in progress |
| dest_match | input | N_DEST | Per-destination routing-match flags for the rebuild |
| dest_pending | input | N_DEST | Per-destination pending flags for the rebuild |
| pending_map | output | N_DEST | Stored destination bitmap |
| pending_count | output | CW | Outstanding acknowledgement count |
| underflow_err | output | 1 | Sticky counter saturation flag |

## Verification
The assertions assume that `eoi_id` and `sync_id` are below N_DEST. They also assume that `dest_match` and `dest_pending` stay steady for the whole walk, since the walk samples them one index per cycle. The stimulus stays within these limits: it uses only in-range indices, it sets both rebuild bitmaps before the start pulse and leaves them alone until `restore_busy` falls, and it changes inputs only on the falling clock edge. Records with a count that does not match their bitmap are sent on purpose, to reach the saturation cases. The assertions do not rely on the count and the map agreeing.

// File: rtl/ept_pkg.sv
package ept_pkg;
  // operation applied to the stored map in one cycle
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_EOI  = 2'd1,
    OP_SET  = 2'd2,
    OP_CLR  = 2'd3
  } ept_op_e;
endpackage

// File: rtl/ept_counter.sv
module ept_counter #(
  parameter int MAXV = 16,
  parameter int CW   = 5
) (
  input  logic [CW-1:0] base,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] nxt,
  output logic          sat_hit
);
  always_comb begin
    nxt     = base;
    sat_hit = 1'b0;
    if (inc && !dec) begin
      if (base >= CW'(MAXV)) sat_hit = 1'b1;
      else                   nxt = base + 1'b1;
    end else if (dec && !inc) begin
      if (base == '0) sat_hit = 1'b1;
      else            nxt = base - 1'b1;
    end
  end
endmodule

// File: rtl/ept_walker.sv
module ept_walker #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          adv,
  output logic          busy,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy && adv) begin
      if (idx == LAST) busy <= 1'b0;
      else             idx  <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/dest_eoi_tracker.sv
module dest_eoi_tracker #(
  parameter  int N_DEST = 16,
  localparam int CW     = $clog2(N_DEST + 1),
  localparam int IW     = (N_DEST > 1) ? $clog2(N_DEST) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  output logic              rec_ready,
  input  logic [N_DEST-1:0] rec_map,
  input  logic [CW-1:0]     rec_count,
  input  logic              eoi_valid,
  input  logic [IW-1:0]     eoi_id,
  input  logic              ask_valid,
  output logic              ans_valid,
  output logic              ans_coalesced,
  input  logic              sync_valid,
  output logic              sync_ready,
  input  logic [IW-1:0]     sync_id,
  input  logic              sync_match,
  input  logic              sync_pending,
  input  logic              restore_start,
  output logic              restore_busy,
  input  logic [N_DEST-1:0] dest_match,
  input  logic [N_DEST-1:0] dest_pending,
  output logic [N_DEST-1:0] pending_map,
  output logic [CW-1:0]     pending_count,
  output logic              underflow_err
);
  import ept_pkg::*;

  localparam logic [CW-1:0] CNT_MAX = CW'(N_DEST);

  logic [N_DEST-1:0] map_q, map_nxt, base_map;
  logic [CW-1:0]     cnt_q, cnt_nxt, base_cnt, ctr_out;
  logic              err_q, ans_v_q, ans_c_q;
  logic              walk_busy, walk_adv, start_go;
  logic [IW-1:0]     walk_idx, step_id, tgt_id;
  logic              step_match, step_pend, step_go, sync_fire, rec_fire;
  logic [N_DEST-1:0] eoi_hit_v, step_bit_v;
  logic              eoi_hit, step_bit, sat_hit;
  ept_op_e           op;

  // handshake and stepping control
  assign start_go   = restore_start && !walk_busy;
  assign rec_ready  = !walk_busy && !restore_start && (cnt_q == '0);
  assign rec_fire   = rec_valid && rec_ready;
  assign sync_ready = !walk_busy && !restore_start && !eoi_valid;
  assign sync_fire  = sync_valid && sync_ready;
  assign walk_adv   = walk_busy && !eoi_valid;
  assign step_go    = walk_adv || sync_fire;

  // delivery record applies before any EOI or step of the same cycle
  assign base_map = rec_fire ? rec_map : map_q;
  assign base_cnt = rec_fire ? ((rec_count > CNT_MAX) ? CNT_MAX : rec_count) : cnt_q;

  assign step_id    = walk_busy ? walk_idx : sync_id;
  assign step_match = walk_busy ? dest_match[walk_idx]   : sync_match;
  assign step_pend  = walk_busy ? dest_pending[walk_idx] : sync_pending;

  // per-destination selection of the addressed bit
  for (genvar g = 0; g < N_DEST; g++) begin : g_sel
    assign eoi_hit_v[g]  = base_map[g] && (eoi_id == IW'(g));
    assign step_bit_v[g] = base_map[g] && (step_id == IW'(g));
  end
  assign eoi_hit  = |eoi_hit_v;
  assign step_bit = |step_bit_v;

  always_comb begin
    op = OP_IDLE;
    if (start_go) begin
      op = OP_IDLE;
    end else if (eoi_valid) begin
      if (eoi_hit) op = OP_EOI;
    end else if (step_go && step_match && (step_pend != step_bit)) begin
      op = step_pend ? OP_SET : OP_CLR;
    end
  end

  assign tgt_id = (op == OP_EOI) ? eoi_id : step_id;

  ept_counter #(.MAXV(N_DEST), .CW(CW)) u_ctr (
    .base    (base_cnt),
    .inc     (op == OP_SET),
    .dec     ((op == OP_EOI) || (op == OP_CLR)),
    .nxt     (ctr_out),
    .sat_hit (sat_hit)
  );

  for (genvar g = 0; g < N_DEST; g++) begin : g_nxt
    always_comb begin
      if (start_go)
        map_nxt[g] = 1'b0;
      else if ((op == OP_SET) && (tgt_id == IW'(g)))
        map_nxt[g] = 1'b1;
      else if (((op == OP_EOI) || (op == OP_CLR)) && (tgt_id == IW'(g)))
        map_nxt[g] = 1'b0;
      else
        map_nxt[g] = base_map[g];
    end
  end

  assign cnt_nxt = start_go ? '0 : ctr_out;

  ept_walker #(.N(N_DEST), .IW(IW)) u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_go),
    .adv   (walk_adv),
    .busy  (walk_busy),
    .idx   (walk_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q   <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      ans_v_q <= 1'b0;
      ans_c_q <= 1'b0;
    end else begin
      map_q   <= map_nxt;
      cnt_q   <= cnt_nxt;
      err_q   <= err_q | (sat_hit && !start_go);
      ans_v_q <= ask_valid;
      ans_c_q <= (cnt_q != '0);
    end
  end

  assign pending_map   = map_q;
  assign pending_count = cnt_q;
  assign underflow_err = err_q;
  assign restore_busy  = walk_busy;
  assign ans_valid     = ans_v_q;
  assign ans_coalesced = ans_c_q;
endmodule

// File: rtl/ept_checker.sv
module ept_checker #(
  parameter  int N_DEST = 16,
  localparam int CW     = $clog2(N_DEST + 1),
  localparam int IW     = (N_DEST > 1) ? $clog2(N_DEST) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rec_valid,
  input logic              rec_ready,
  input logic [N_DEST-1:0] rec_map,
  input logic              eoi_valid,
  input logic [IW-1:0]     eoi_id,
  input logic              ask_valid,
  input logic              ans_valid,
  input logic              ans_coalesced,
  input logic              sync_ready,
  input logic              restore_start,
  input logic              restore_busy,
  input logic [N_DEST-1:0] pending_map,
  input logic [CW-1:0]     pending_count,
  input logic              underflow_err
);
  assert_rec_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_ready) |-> (pending_count == '0));

  assert_rec_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_ready && !eoi_valid) |=> (pending_map == $past(rec_map)));

  assert_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ask_valid |=> (ans_valid && (ans_coalesced == ($past(pending_count) != '0))));

  assert_eoi_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && !restore_start && !(rec_valid && rec_ready)
     && pending_map[eoi_id] && (pending_count != '0))
    |=> (!pending_map[$past(eoi_id)] && (pending_count == $past(pending_count) - 1'b1)));

  assert_count_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pending_count <= CW'(N_DEST));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |=> underflow_err);

  assert_restore_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_start && !restore_busy) |=> (restore_busy && (pending_map == '0) && (pending_count == '0)));

  assert_busy_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restore_busy |-> (!rec_ready && !sync_ready));

  assert_eoi_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> !sync_ready);
endmodule

bind dest_eoi_tracker ept_checker #(.N_DEST(N_DEST)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rec_valid     (rec_valid),
  .rec_ready     (rec_ready),
  .rec_map       (rec_map),
  .eoi_valid     (eoi_valid),
  .eoi_id        (eoi_id),
  .ask_valid     (ask_valid),
  .ans_valid     (ans_valid),
  .ans_coalesced (ans_coalesced),
  .sync_ready    (sync_ready),
  .restore_start (restore_start),
  .restore_busy  (restore_busy),
  .pending_map   (pending_map),
  .pending_count (pending_count),
  .underflow_err (underflow_err)
);

// File: tb/tb_dest_eoi_tracker.sv
module tb_dest_eoi_tracker;
  localparam int N  = 16;
  localparam int CW = $clog2(N + 1);
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rec_valid = 0, eoi_valid = 0, ask_valid = 0, sync_valid = 0;
  logic sync_match = 0, sync_pending = 0, restore_start = 0;
  logic [N-1:0] rec_map = '0, dest_match = '0, dest_pending = '0;
  logic [CW-1:0] rec_count = '0;
  logic [IW-1:0] eoi_id = '0, sync_id = '0;
  logic rec_ready, ans_valid, ans_coalesced, sync_ready, restore_busy, underflow_err;
  logic [N-1:0] pending_map;
  logic [CW-1:0] pending_count;

  always #10 clk = ~clk; // 50 MHz

  dest_eoi_tracker #(.N_DEST(N)) dut (
    .clk(clk), .rst_n(rst_n),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_map(rec_map), .rec_count(rec_count),
    .eoi_valid(eoi_valid), .eoi_id(eoi_id),
    .ask_valid(ask_valid), .ans_valid(ans_valid), .ans_coalesced(ans_coalesced),
    .sync_valid(sync_valid), .sync_ready(sync_ready), .sync_id(sync_id),
    .sync_match(sync_match), .sync_pending(sync_pending),
    .restore_start(restore_start), .restore_busy(restore_busy),
    .dest_match(dest_match), .dest_pending(dest_pending),
    .pending_map(pending_map), .pending_count(pending_count), .underflow_err(underflow_err)
  );

  int checks = 0;
  int failures = 0;

  // expected state, built from the requirements
  logic [N-1:0] m_map = '0;
  int  m_cnt = 0;
  bit  m_err = 0;
  bit  m_busy = 0;
  int  m_idx = 0;
  bit  ans_q[$];

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic m_inc(inout int c);
    if (c >= N) m_err = 1; else c++;
  endtask

  task automatic m_dec(inout int c);
    if (c == 0) m_err = 1; else c--;
  endtask

  task automatic m_resync(inout logic [N-1:0] mp, inout int c, input int id, input bit mt, input bit pd);
    if (mt && (pd != mp[id])) begin
      mp[id] = pd;
      if (pd) m_inc(c); else m_dec(c);
    end
  endtask

  task automatic model_step();
    logic [N-1:0] mp;
    int c;
    if (ask_valid) ans_q.push_back(m_cnt != 0);
    if (restore_start && !m_busy) begin
      m_map = '0; m_cnt = 0; m_busy = 1; m_idx = 0;
    end else begin
      mp = m_map; c = m_cnt;
      if (rec_valid && !m_busy && m_cnt == 0) begin
        mp = rec_map;
        c = (int'(rec_count) > N) ? N : int'(rec_count);
      end
      if (eoi_valid) begin
        if (mp[eoi_id]) begin mp[eoi_id] = 1'b0; m_dec(c); end
      end else if (m_busy) begin
        m_resync(mp, c, m_idx, dest_match[m_idx], dest_pending[m_idx]);
        if (m_idx == N - 1) m_busy = 0; else m_idx++;
      end else if (sync_valid) begin
        m_resync(mp, c, int'(sync_id), sync_match, sync_pending);
      end
      m_map = mp; m_cnt = c;
    end
  endtask

  // one clock of stimulus: inputs are already set just after a falling edge
  task automatic tick(string tag);
    #1;
    chk(tag, "rec_ready", rec_ready, !m_busy && !restore_start && (m_cnt == 0));
    chk(tag, "sync_ready", sync_ready, !m_busy && !restore_start && !eoi_valid);
    model_step();
    @(negedge clk);
    rec_valid = 0; eoi_valid = 0; ask_valid = 0; sync_valid = 0; restore_start = 0;
    chk(tag, "pending_map", pending_map, m_map);
    chk(tag, "pending_count", pending_count, m_cnt);
    chk(tag, "underflow_err", underflow_err, m_err);
    chk(tag, "restore_busy", restore_busy, m_busy);
  endtask

  task automatic do_rec(string tag, logic [N-1:0] mp, int c);
    rec_valid = 1; rec_map = mp; rec_count = CW'(c); tick(tag);
  endtask

  task automatic do_eoi(string tag, int id);
    eoi_valid = 1; eoi_id = IW'(id); tick(tag);
  endtask

  task automatic do_ask(string tag);
    ask_valid = 1; tick(tag);
  endtask

  task automatic do_sync(string tag, int id, bit mt, bit pd);
    sync_valid = 1; sync_id = IW'(id); sync_match = mt; sync_pending = pd; tick(tag);
  endtask

  // scoreboard monitor for query answers (R2)
  always @(negedge clk) begin
    if (rst_n && ans_valid) begin
      if (ans_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R2 unexpected answer actual=1 expected=0");
      end else begin
        chk("R2", "ans_coalesced", ans_coalesced, ans_q.pop_front());
      end
    end
  end

  initial begin
    #4_000_000;
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1", "pending_count", pending_count, 0);
    chk("R1", "pending_map", pending_map, 0);
    chk("R1", "underflow_err", underflow_err, 0);
    chk("R1", "restore_busy", restore_busy, 0);
    chk("R1", "ans_valid", ans_valid, 0);

    do_ask("R2");                         // idle: not coalesced
    do_rec("R3", 16'h0015, 3);
    do_ask("R2");                         // outstanding: coalesced
    do_rec("R3", 16'h00FF, 8);            // refused, count non-zero
    chk("R3", "literal map", pending_map, 16'h0015);
    do_eoi("R4", 1);                      // bit clear: no effect
    do_eoi("R4", 2);
    chk("R4", "literal count", pending_count, 2);
    do_eoi("R4", 0);
    do_eoi("R4", 4);
    do_ask("R2");

    // R5: record and EOI in the same cycle
    rec_valid = 1; rec_map = 16'h0003; rec_count = 2;
    eoi_valid = 1; eoi_id = 1;
    tick("R5");
    chk("R5", "literal map", pending_map, 16'h0001);
    do_eoi("R5", 0);

    // R6: single resync steps
    do_sync("R6", 5, 1, 1);
    chk("R6", "literal count", pending_count, 1);
    do_sync("R6", 5, 0, 0);
    do_sync("R6", 5, 1, 1);
    do_sync("R6", 5, 1, 0);
    // R8: resync alongside EOI is held off
    sync_valid = 1; sync_id = 6; sync_match = 1; sync_pending = 1;
    eoi_valid = 1; eoi_id = 6;
    tick("R8");
    chk("R8", "literal map", pending_map, 16'h0000);

    // R9: underflow and overflow saturate, R10: flag stays
    do_rec("R9", 16'h0100, 0);
    do_eoi("R9", 8);
    chk("R9", "literal err", underflow_err, 1);
    do_ask("R10");
    do_rec("R9", 16'h0000, 16);
    do_sync("R9", 3, 1, 1);
    chk("R9", "literal count", pending_count, 16);
    chk("R10", "literal err", underflow_err, 1);

    // R7: full rebuild, with an EOI stalling the walk (R8)
    dest_match = 16'hF0F0; dest_pending = 16'hFF00;
    restore_start = 1;
    tick("R7");
    for (int k = 0; k < 40 && m_busy; k++) begin
      if (k == 5) begin eoi_valid = 1; eoi_id = 15; end
      if (k == 7) begin rec_valid = 1; rec_map = 16'h0001; rec_count = 1; end
      tick(k == 5 ? "R8" : "R7");
    end
    chk("R7", "literal map", pending_map, 16'hF000);
    chk("R7", "literal count", pending_count, 4);
    chk("R10", "literal err", underflow_err, 1);
    do_ask("R2");
    for (int d = 12; d < 16; d++) do_eoi("R4", d);
    do_ask("R2");
    repeat (2) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule